// File: doc/BRIEF.md
# Paged open-drain GPIO register file

This block is a byte-wide register file that controls 48 open-drain I/O lines, arranged as six 8-bit ports. A simple synchronous bus reaches the registers. The bus has a 4-bit address, write data, a write strobe, a read strobe and registered read data.

Each port register holds the output latches that drive per-line pull-low enables. Reading a port returns the synchronized pin levels in inverted form. A combined register holds two things: a write-lock bit for each port, and a two-bit page select. Three addresses at the top of the map form a window that the page select steers to an attached interrupt unit. The interrupt unit holds the polarity, enable and identification registers and does the edge detection. A read-only pending byte from that unit is also visible on the bus.

Software writes a port to pull lines low. It locks a port to freeze its outputs. It selects a page before it touches the window registers.

Top module: `gpio_paged_regs`

## Requirements
- R1: After reset, all pull-low enables are 0 (every line released), all lock bits are 0, the page select is 0, and read data is 0.
- R2: A write to address 0..5 loads the write data into that port's latch one clock later. Bit n of port p drives pull_low_o[8p+n] (1 = sink current, 0 = high impedance). No other port changes.
- R3: A read of address 0..5 returns the bitwise inverse of that port's pins after a two-flop synchronizer (1 = pin low). A pin change becomes visible to a read that is captured on the third rising edge after the change.
- R4: rdata_o is registered. It takes the addressed value on the clock edge where rd_i is high, and it holds its value while rd_i is low.
- R5: Address 7 holds the lock bits for ports 0..5 in bits 5:0 and the page select in bits 7:6. A write stores both fields, and a read returns them.
- R6: While a port's lock bit is 1, writes to that port leave its latch unchanged. The other ports still accept writes, and clearing the lock bit makes the port writable again.
- R7: On pages 1..3, a write or read at address 8..10 pulses win_wr_o or win_rd_o in the same cycle. In that cycle win_page_o is the page, win_sel_o is the address minus 8, and win_wdata_o is the write data. A read returns win_rdata_i.
- R8: On page 0, addresses 8..10 read as 0 and raise no window strobe.
- R9: Address 6 reads pend_i. Writes to address 6 change no latch, lock, page or window strobe.
- R10: Addresses 11..15 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pin_i | input | 48 | Sampled pad levels |
| pull_low_o | output | 48 | Per-line pull-low enables |
| pend_i | input | 8 | Pending byte from the interrupt unit |
| win_wr_o | output | 1 | Window write strobe |
| win_rd_o | output | 1 | Window read strobe |
| win_page_o | output | 2 | Page of the window access |
| win_sel_o | output | 2 | Register index 0..2 within the page |
| win_wdata_o | output | 8 | Window write data |
| win_rdata_i | input | 8 | Window read data from the interrupt unit |

## Verification
The bench drives a locked port with all-ones data. A design that ignores the lock would show the new value on the pull-low pins. It then clears the lock to catch a design whose lock sticks. The bench reads a freshly pulled-down pin on three successive cycles, which catches a synchronizer that is missing or one stage too deep. It also checks that read data is inverted, so a design that returns raw levels fails. Window accesses are made on page 0, on page 3 and at unmapped addresses. A decoder that ignores the page, or that aliases high addresses into the window, would raise a stray strobe or return non-zero data. A write to the pending address is followed by port and pending reads, which catches a decoder that aliases address 6 onto a port.

// File: rtl/gpio_paged_pkg.sv
package gpio_paged_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned PAGE_W   = 2;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 4'h6;
  localparam logic [ADDR_W-1:0] ADDR_PGLK = 4'h7;
  localparam logic [ADDR_W-1:0] WIN_BASE  = 4'h8;
  localparam int unsigned WIN_CNT  = 3;
  typedef logic [PAGE_W-1:0] page_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  // idle lines float high, so reset to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank #(
  parameter int unsigned PORTS  = 6,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LINES = PORTS * PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] sel_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic [PORTS-1:0]  lock_i,
  output logic [LINES-1:0]  latch_o
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [PORT_W-1:0] lat_q;
    logic              we;
    assign we = wr_i && (sel_i == ADDR_W'(p)) && !lock_i[p];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  lat_q <= '0;
      else if (we)  lat_q <= wdata_i;
    end
    assign latch_o[p*PORT_W +: PORT_W] = lat_q;
  end
endmodule

// File: rtl/gpio_win_route.sv
module gpio_win_route
  import gpio_paged_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  page_t             page_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic              win_wr_o,
  output logic              win_rd_o,
  output page_t             win_page_o,
  output logic [1:0]        win_sel_o,
  output logic [DATA_W-1:0] win_wdata_o
);
  logic in_range;
  logic [ADDR_W-1:0] offs;

  assign offs     = addr_i - WIN_BASE;
  assign in_range = (addr_i >= WIN_BASE) && (offs < ADDR_W'(WIN_CNT));
  // page 0 leaves the window unmapped
  assign hit_o    = in_range && (page_i != '0);

  assign win_wr_o    = hit_o && wr_i;
  assign win_rd_o    = hit_o && rd_i;
  assign win_page_o  = page_i;
  assign win_sel_o   = offs[1:0];
  assign win_wdata_o = wdata_i;
endmodule

// File: rtl/gpio_paged_regs.sv
module gpio_paged_regs
  import gpio_paged_pkg::*;
#(
  parameter int unsigned PORTS  = 6,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LINES = PORTS * PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [LINES-1:0]  pin_i,
  output logic [LINES-1:0]  pull_low_o,
  input  logic [DATA_W-1:0] pend_i,
  output logic              win_wr_o,
  output logic              win_rd_o,
  output logic [1:0]        win_page_o,
  output logic [1:0]        win_sel_o,
  output logic [DATA_W-1:0] win_wdata_o,
  input  logic [DATA_W-1:0] win_rdata_i
);
  logic [PORTS-1:0]  lock_q;
  page_t             page_q;
  logic [LINES-1:0]  pin_sync;
  logic              win_hit;
  logic [DATA_W-1:0] rd_next;

  gpio_in_sync #(.W(LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_out_bank #(.PORTS(PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .sel_i  (addr_i),
    .wdata_i(wdata_i[PORT_W-1:0]),
    .lock_i (lock_q),
    .latch_o(pull_low_o)
  );

  gpio_win_route #(.DATA_W(DATA_W)) u_win (
    .addr_i     (addr_i),
    .page_i     (page_q),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .hit_o      (win_hit),
    .win_wr_o   (win_wr_o),
    .win_rd_o   (win_rd_o),
    .win_page_o (win_page_o),
    .win_sel_o  (win_sel_o),
    .win_wdata_o(win_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      page_q <= '0;
    end else if (wr_i && addr_i == ADDR_PGLK) begin
      lock_q <= wdata_i[PORTS-1:0];
      page_q <= wdata_i[DATA_W-1 -: PAGE_W];
    end
  end

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (addr_i == ADDR_W'(p))
        rd_next[PORT_W-1:0] = ~pin_sync[p*PORT_W +: PORT_W];
    end
    if (addr_i == ADDR_PEND) rd_next = pend_i;
    if (addr_i == ADDR_PGLK) begin
      rd_next[PORTS-1:0]          = lock_q;
      rd_next[DATA_W-1 -: PAGE_W] = page_q;
    end
    if (win_hit) rd_next = win_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_next;
  end
endmodule

// File: rtl/gpio_paged_regs_checker.sv
module gpio_paged_regs_checker
  import gpio_paged_pkg::*;
#(
  parameter int unsigned PORTS  = 6,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LINES = PORTS * PORT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [LINES-1:0]  pull_low_o,
  input logic              win_wr_o,
  input logic              win_rd_o,
  input logic [1:0]        win_page_o,
  input logic [DATA_W-1:0] win_rdata_i,
  input logic [PORTS-1:0]  lock_q
);
  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(lock_q[p]) |-> $stable(pull_low_o[p*PORT_W +: PORT_W])) else $error("lock"); // R6
    AST_LATCH_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(pull_low_o[p*PORT_W +: PORT_W]) |-> $past(wr_i && addr_i == 4'(p))) else $error("latch"); // R2
  end

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)) else $error("hold"); // R4
  AST_PAGE0_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_wr_o || win_rd_o) |-> win_page_o != 2'd0) else $error("page0"); // R8
  AST_WIN_RD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_rd_o |-> rd_i && addr_i >= WIN_BASE && addr_i < WIN_BASE + 4'(WIN_CNT)) else $error("wincause"); // R7
  AST_WIN_RD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_rd_o |=> rdata_o == $past(win_rdata_i)) else $error("windata"); // R7
  AST_HIGH_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i > 4'hA) |=> rdata_o == '0) else $error("high"); // R10
  AST_HIGH_ADDR_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > 4'hA) |-> !(win_wr_o || win_rd_o)) else $error("highstb"); // R10
endmodule

bind gpio_paged_regs gpio_paged_regs_checker #(
  .PORTS(PORTS), .PORT_W(PORT_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .pull_low_o (pull_low_o),
  .win_wr_o   (win_wr_o),
  .win_rd_o   (win_rd_o),
  .win_page_o (win_page_o),
  .win_rdata_i(win_rdata_i),
  .lock_q     (lock_q)
);

// File: tb/gpio_paged_regs_test.sv
`timescale 1ns/1ps
module gpio_paged_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic [47:0] pin, pull_low, ext_low = '0;
  logic [7:0]  pend = 8'h5A;
  logic        win_wr, win_rd;
  logic [1:0]  win_page, win_sel;
  logic [7:0]  win_wdata, win_rdata;
  int checks = 0, failures = 0;
  int win_wr_cnt = 0;
  logic [1:0] last_pg = '0, last_sel = '0;
  logic [7:0] last_wd = '0;

  always #2.5 clk = ~clk;

  // open-drain pads: low when the block or the outside pulls down
  assign pin = ~(pull_low | ext_low);
  // interrupt-unit stub
  assign win_rdata = {win_page, 4'b1010, win_sel};
  always @(posedge clk) if (win_wr) begin
    win_wr_cnt <= win_wr_cnt + 1;
    last_pg <= win_page; last_sel <= win_sel; last_wd <= win_wdata;
  end

  gpio_paged_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .pin_i(pin), .pull_low_o(pull_low), .pend_i(pend),
    .win_wr_o(win_wr), .win_rd_o(win_rd), .win_page_o(win_page), .win_sel_o(win_sel),
    .win_wdata_o(win_wdata), .win_rdata_i(win_rdata)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    repeat (3) @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  // {read, addr, data, expected}
  localparam int NV = 23;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'h7, 8'h00, 8'h00},  // R1 page/lock clear
    {1'b1, 4'h0, 8'h00, 8'h00},  // R1 R3 all pins high
    {1'b0, 4'h0, 8'hA5, 8'h00},
    {1'b1, 4'h0, 8'h00, 8'hA5},  // R2 R3
    {1'b0, 4'h3, 8'h0F, 8'h00},
    {1'b1, 4'h3, 8'h00, 8'h0F},  // R2
    {1'b0, 4'h7, 8'h02, 8'h00},  // lock port 1
    {1'b0, 4'h1, 8'hFF, 8'h00},
    {1'b1, 4'h1, 8'h00, 8'h00},  // R6 locked
    {1'b0, 4'h2, 8'h3C, 8'h00},
    {1'b1, 4'h2, 8'h00, 8'h3C},  // R6 neighbour
    {1'b1, 4'h7, 8'h00, 8'h02},  // R5
    {1'b0, 4'h7, 8'h00, 8'h00},  // unlock
    {1'b0, 4'h1, 8'h81, 8'h00},
    {1'b1, 4'h1, 8'h00, 8'h81},  // R6 unlocked
    {1'b1, 4'h8, 8'h00, 8'h00},  // R8
    {1'b0, 4'h7, 8'hC0, 8'h00},  // page 3
    {1'b1, 4'h7, 8'h00, 8'hC0},  // R5
    {1'b1, 4'h9, 8'h00, 8'hE9},  // R7 page 3 sel 1
    {1'b1, 4'hC, 8'h00, 8'h00},  // R10
    {1'b0, 4'h6, 8'hFF, 8'h00},
    {1'b1, 4'h6, 8'h00, 8'h5A},  // R9
    {1'b1, 4'h0, 8'h00, 8'hA5}   // R9 write to 6 did not alias
  };
  string vreq [NV];

  initial begin
    repeat (40000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cnt0;
    vreq = '{"R1","R1","-","R3","-","R2","-","-","R6","-","R6","R5","-","-","R6",
             "R8","-","R5","R7","R10","-","R9","R9"};
    #1;
    check("R1", {40'h0, rdata}, 48'h0);
    check("R1", pull_low, 48'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        bus_rd(VEC[i][19:16], d);
        check(vreq[i], {40'h0, d}, {40'h0, VEC[i][7:0]});
      end else begin
        bus_wr(VEC[i][19:16], VEC[i][15:8]);
      end
    end

    // R2 pins
    check("R2", pull_low, 48'h0000_0F3C_81A5);

    // R3 synchronizer depth and inversion via outside pull-down
    @(negedge clk); ext_low[40] = 1'b1; addr = 4'h5; rd = 1'b1;
    @(negedge clk); check("R3", {40'h0, rdata}, 48'h0);
    @(negedge clk); check("R3", {40'h0, rdata}, 48'h0);
    @(negedge clk); rd = 1'b0; check("R3", {40'h0, rdata}, 48'h01);

    // R4 hold while idle
    ext_low[40] = 1'b0;
    repeat (5) @(negedge clk);
    check("R4", {40'h0, rdata}, 48'h01);

    // R7 window write on page 2
    bus_wr(4'h7, 8'h80);
    cnt0 = win_wr_cnt;
    bus_wr(4'hA, 8'h77);
    check("R7", 48'(win_wr_cnt - cnt0), 48'd1);
    check("R7", {44'h0, last_pg, last_sel}, {44'h0, 2'd2, 2'd2});
    check("R7", {40'h0, last_wd}, 48'h77);

    // R8 page 0 write raises no strobe
    bus_wr(4'h7, 8'h00);
    cnt0 = win_wr_cnt;
    bus_wr(4'h8, 8'h11);
    check("R8", 48'(win_wr_cnt - cnt0), 48'd0);

    // R10 high address write: no strobe, no state change
    bus_wr(4'h7, 8'h40);
    cnt0 = win_wr_cnt;
    bus_wr(4'hD, 8'hFF);
    check("R10", 48'(win_wr_cnt - cnt0), 48'd0);
    check("R10", pull_low, 48'h0000_0F3C_81A5);
    bus_rd(4'h7, d);
    check("R10", {40'h0, d}, 48'h40);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1", pull_low, 48'h0);
    check("R1", {40'h0, rdata}, 48'h0);
    rst_n = 1'b1;
    bus_rd(4'h7, d);
    check("R1", {40'h0, d}, 48'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule